// File: doc/BRIEF.md
# Multi-Source Reset Pulse Controller

This block merges a set of reset requests into one active-low system reset line that is shared with other parties on the board. Whenever a request arrives, the block pulls the line low and keeps it low for a stretched length: a short pulse of `SHORT_TICKS` millisecond ticks or a long pulse of `LONG_TICKS` ticks. A configuration bit picks the length. Time is counted only in strobes on `tick_i`, which is expected once per millisecond.

The block samples the same line back through a synchronizer. A falling edge driven by some other party counts as a reset request of its own. Such an edge also forces the long-pulse bit on, as does entry to restart mode. A pulse that turned out too short for the processor is therefore repeated with the long length. The block latches the cause of the most recent pulse as a 4-bit source code. After an outside reset it reports start-up. If the line is still held low once its own pulse has ended, it counts a watch window. When the window runs out, it raises a sticky fail-safe request.

Top module: `rst_pulse_ctrl`

## Requirements
- R1: `src_code_o` holds the code of the last pulse cause and is 0 after reset. The codes are: 1 power-on, 2 outside reset, 3 to 14 for `evt_i[0]` to `evt_i[11]`. The event inputs are, in order: supply low, standby overcurrent, short while sleeping, flash preparation done, flash exit, wake-up, fail-safe wake-up, watchdog early, watchdog overflow, watchdog wrong code, illegal mode code, interrupt timeout. The code is not cleared by any later activity other than a new pulse.
- R2: A pulse asserts `rst_drive_o` from the clock edge that samples the request. It releases the line at the edge that samples the N-th `tick_i` strobe after that. N is `SHORT_TICKS` (1) when `long_len_o` is 0 and `LONG_TICKS` (20) when it is 1.
- R3: After `rst_ni` the line is driven low while `supply_ok_i` is 0. `long_len_o` is 0. Once `supply_ok_i` is seen high, a short pulse with code 1 follows, and the line stays low without a gap between the wait and the pulse.
- R4: A `cfg_wr_i` strobe loads `cfg_long_i` into `long_len_o`.
- R5: A `restart_i` strobe sets `long_len_o` to 1.
- R6: A falling edge on `rst_line_i` caused by another party starts a pulse with code 2. The same edge sets `long_len_o` to 1, and this pulse is already long.
- R7: The block's own pulses never register as an outside reset. After such a pulse the code and `long_len_o` are unchanged.
- R8: When several requests arrive in the same cycle, the lowest code wins.
- R9: A request during an active pulse restarts the tick count with the current length and replaces the code.
- R10: `startup_o` rises after an outside reset. It falls once the line is seen released after the block's own pulse.
- R11: If the line stays low for `WIN_TICKS` ticks after the block's own pulse has ended, `failsafe_req_o` rises and `startup_o` falls. `failsafe_req_o` then stays high until `rst_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, treated as power-on |
| tick_i | input | 1 | One-cycle strobe every millisecond |
| supply_ok_i | input | 1 | Main supply reported present |
| evt_i | input | 12 | One-cycle reset request strobes, bit i gives code i+3 |
| restart_i | input | 1 | Strobe on entry to restart mode |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_long_i | input | 1 | Long-pulse bit value written by cfg_wr_i |
| rst_line_i | input | 1 | Sampled level of the shared reset line |
| rst_drive_o | output | 1 | 1 pulls the shared line low |
| long_len_o | output | 1 | Current long-pulse bit |
| src_code_o | output | 4 | Code of the last pulse cause |
| startup_o | output | 1 | Start-up after an outside reset |
| failsafe_req_o | output | 1 | Sticky fail-safe escalation request |

## Verification
The assertions rely on three properties of the inputs. `tick_i` and the request inputs are single-cycle strobes. The shared line reads low whenever `rst_drive_o` is high. A pulse ends only through a sampled tick. The bench models the line as an open-drain wire: it is low when either the block or the modelled outside party pulls it. The bench raises requests and `supply_ok_i` only in cycles without a tick, so the tick count it scores for each pulse matches the count the block uses.

// File: rtl/rst_pkg.sv
package rst_pkg;
  localparam int SRC_W   = 4;
  localparam int NUM_EVT = 12;
  localparam int NUM_SRC = NUM_EVT + 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE     = 4'd0,
    SRC_POR      = 4'd1,
    SRC_EXT      = 4'd2,
    SRC_VLOW     = 4'd3,
    SRC_STBY_OC  = 4'd4,
    SRC_SLP_SHRT = 4'd5,
    SRC_FL_PREP  = 4'd6,
    SRC_FL_EXIT  = 4'd7,
    SRC_WAKE     = 4'd8,
    SRC_FS_WAKE  = 4'd9,
    SRC_WD_EARLY = 4'd10,
    SRC_WD_OVF   = 4'd11,
    SRC_WD_CODE  = 4'd12,
    SRC_ILL_MODE = 4'd13,
    SRC_IRQ_TMO  = 4'd14
  } src_e;
endpackage

// File: rtl/rst_line_sync.sv
module rst_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic drive_i,
  output logic line_o,
  output logic fall_o
);
  logic s1_q, s2_q, s3_q;
  logic drv1_q, drv2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      drv1_q <= 1'b1;
      drv2_q <= 1'b1;
    end else begin
      s1_q   <= line_i;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      drv1_q <= drive_i;
      drv2_q <= drv1_q;
    end
  end

  // drv2_q is aligned with s2_q: a low caused by our own drive is masked
  assign fall_o = s3_q & ~s2_q & ~drv2_q;
  assign line_o = s2_q;

  // R7
  own_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drive_i && $past(drive_i) && $past(drive_i, 2)) |-> !fall_o);
endmodule

// File: rtl/rst_src_arb.sv
module rst_src_arb
  import rst_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  output logic               valid_o,
  output logic [SRC_W-1:0]   code_o
);
  logic [NUM_SRC:0]   taken;
  logic [NUM_SRC-1:0] gnt;

  assign taken[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
    assign gnt[i]     = req_i[i] & ~taken[i];
    assign taken[i+1] = taken[i] | req_i[i];
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (gnt[i]) code_o = code_o | SRC_W'(i + 1);
    end
  end

  assign valid_o = taken[NUM_SRC];
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch
  import rst_pkg::*;
#(
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SRC_W-1:0] code_i,
  input  logic             long_i,
  input  logic             tick_i,
  output logic             active_o,
  output logic [SRC_W-1:0] src_o
);
  localparam int CNT_W = $clog2(LONG_TICKS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  logic [SRC_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      src_q    <= SRC_NONE;
    end else if (start_i) begin
      cnt_q    <= long_i ? CNT_W'(LONG_TICKS) : CNT_W'(SHORT_TICKS);
      active_q <= 1'b1;
      src_q    <= code_i;
    end else if (active_q && tick_i) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign src_o    = src_q;

  // R2
  end_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> $past(tick_i));
  // R2
  hold_mid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !tick_i) |=> active_q);
  // R1
  src_on_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_q != $past(src_q)) |-> active_q);
endmodule

// File: rtl/rst_release_mon.sv
module rst_release_mon #(
  parameter int WIN_TICKS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic active_i,
  input  logic line_i,
  input  logic tick_i,
  output logic startup_o,
  output logic failsafe_o
);
  localparam int WIN_W = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1;

  logic [WIN_W-1:0] win_q;
  logic             startup_q, fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q     <= '0;
      startup_q <= 1'b0;
      fail_q    <= 1'b0;
    end else if (ext_i) begin
      startup_q <= 1'b1;
      win_q     <= '0;
    end else if (startup_q && !active_i) begin
      if (line_i) begin
        startup_q <= 1'b0;
      end else if (tick_i) begin
        if (win_q == WIN_W'(WIN_TICKS - 1)) begin
          fail_q    <= 1'b1;
          startup_q <= 1'b0;
        end else begin
          win_q <= win_q + WIN_W'(1);
        end
      end
    end
  end

  assign startup_o  = startup_q;
  assign failsafe_o = fail_q;

  // R11
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_q |=> fail_q);
  // R10
  startup_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(startup_q) |-> $past(ext_i));
  // R11
  fail_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> ($past(tick_i) && !$past(line_i)));
endmodule

// File: rtl/rst_pulse_ctrl.sv
module rst_pulse_ctrl
  import rst_pkg::*;
#(
  parameter int SHORT_TICKS = 1,
  parameter int LONG_TICKS  = 20,
  parameter int WIN_TICKS   = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               supply_ok_i,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               restart_i,
  input  logic               cfg_wr_i,
  input  logic               cfg_long_i,
  input  logic               rst_line_i,
  output logic               rst_drive_o,
  output logic               long_len_o,
  output logic [SRC_W-1:0]   src_code_o,
  output logic               startup_o,
  output logic               failsafe_req_o
);
  logic               por_pend_q, long_q;
  logic               por_fire, ext_fall, line_s;
  logic               req_valid, active;
  logic [SRC_W-1:0]   req_code;
  logic [NUM_SRC-1:0] req;

  assign por_fire = por_pend_q & supply_ok_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_pend_q <= 1'b1;
      long_q     <= 1'b0;
    end else begin
      if (supply_ok_i) por_pend_q <= 1'b0;
      if (ext_fall || restart_i) long_q <= 1'b1;
      else if (cfg_wr_i)         long_q <= cfg_long_i;
    end
  end

  rst_line_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .line_i  (rst_line_i),
    .drive_i (rst_drive_o),
    .line_o  (line_s),
    .fall_o  (ext_fall)
  );

  assign req = {evt_i, ext_fall, por_fire};

  rst_src_arb u_arb (
    .req_i   (req),
    .valid_o (req_valid),
    .code_o  (req_code)
  );

  rst_stretch #(
    .SHORT_TICKS (SHORT_TICKS),
    .LONG_TICKS  (LONG_TICKS)
  ) u_stretch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (req_valid),
    .code_i   (req_code),
    .long_i   (long_q | ext_fall),
    .tick_i   (tick_i),
    .active_o (active),
    .src_o    (src_code_o)
  );

  rst_release_mon #(
    .WIN_TICKS (WIN_TICKS)
  ) u_mon (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_i      (ext_fall),
    .active_i   (active),
    .line_i     (line_s),
    .tick_i     (tick_i),
    .startup_o  (startup_o),
    .failsafe_o (failsafe_req_o)
  );

  assign rst_drive_o = active | por_pend_q;
  assign long_len_o  = long_q;

  // R6
  ext_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_fall |=> long_q);
  // R5
  restart_long_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> long_q);
  // R3
  por_gapless_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(por_pend_q) |-> (active && src_code_o == SRC_POR));
endmodule

// File: tb/rst_pulse_ctrl_tb_top.sv
`timescale 1ns/1ps
module rst_pulse_ctrl_tb_top;
  localparam int WIN = 256;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        tick_en = 1'b0;
  logic        supply_ok_i = 1'b0;
  logic [11:0] evt_i = '0;
  logic        restart_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        cfg_long_i = 1'b0;
  logic        ext_pull = 1'b0;
  logic        rst_line_i;
  logic        rst_drive_o, long_len_o, startup_o, failsafe_req_o;
  logic [3:0]  src_code_o;

  int n_chk = 0;
  int n_bad = 0;
  int tcnt = 0;
  int q_tk[$];
  int q_code[$];
  string q_tag[$];

  always #4 clk = ~clk;

  assign rst_line_i = ~(rst_drive_o | ext_pull);

  rst_pulse_ctrl dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .tick_i         (tick_i),
    .supply_ok_i    (supply_ok_i),
    .evt_i          (evt_i),
    .restart_i      (restart_i),
    .cfg_wr_i       (cfg_wr_i),
    .cfg_long_i     (cfg_long_i),
    .rst_line_i     (rst_line_i),
    .rst_drive_o    (rst_drive_o),
    .long_len_o     (long_len_o),
    .src_code_o     (src_code_o),
    .startup_o      (startup_o),
    .failsafe_req_o (failsafe_req_o)
  );

  always @(posedge clk) begin
    #2;
    tcnt++;
    tick_i = tick_en && (tcnt % 4 == 0);
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  // monitor: counts ticks seen while the line is driven, scores each finished pulse
  int  mon_tk = 0;
  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (mon_prev && !rst_drive_o) begin
        if (q_tk.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 unexpected pulse act=%0d exp=none", mon_tk);
        end else begin
          chk({q_tag.pop_front(), " ticks"}, mon_tk, q_tk.pop_front());
          chk("R1 code", int'(src_code_o), q_code.pop_front());
        end
        mon_tk = 0;
      end
      if (rst_drive_o && tick_i) mon_tk++;
      mon_prev = rst_drive_o;
    end
  end

  task automatic step();
    @(posedge clk); #3;
  endtask

  task automatic expect_pulse(input int tk, input int code, input string tag);
    q_tk.push_back(tk); q_code.push_back(code); q_tag.push_back(tag);
  endtask

  task automatic fire(input logic [11:0] bits);
    while (tick_i) step();
    evt_i = bits;
    step();
    evt_i = '0;
  endtask

  task automatic wait_idle();
    while (rst_drive_o) step();
    repeat (4) step();
  endtask

  task automatic cfg(input logic v);
    cfg_wr_i = 1'b1; cfg_long_i = v;
    step();
    cfg_wr_i = 1'b0;
    step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(posedge clk);
    #3 rst_ni = 1'b1;
    repeat (5) step();
    // R3: held low while waiting for supply
    chk("R3 drive while no supply", int'(rst_drive_o), 1);
    chk("R1 code after reset", int'(src_code_o), 0);
    chk("R3 long bit after power-on", int'(long_len_o), 0);
    chk("R11 failsafe after reset", int'(failsafe_req_o), 0);
    expect_pulse(1, 1, "R3 power-on");
    supply_ok_i = 1'b1;
    step();
    tick_en = 1'b1;
    wait_idle();

    // R2 short pulses, R1 code map
    expect_pulse(1, 3, "R2 short supply low");
    fire(12'h001); wait_idle();
    // R7 own pulse not an outside event
    chk("R7 code kept", int'(src_code_o), 3);
    chk("R7 long kept", int'(long_len_o), 0);
    chk("R7 line released", int'(rst_drive_o), 0);
    expect_pulse(1, 14, "R1 interrupt timeout");
    fire(12'h800); wait_idle();
    expect_pulse(1, 8, "R1 wake");
    fire(12'h020); wait_idle();

    // R8 simultaneous
    expect_pulse(1, 5, "R8 priority");
    fire(12'h084); wait_idle();

    // R4 config write
    cfg(1'b1);
    chk("R4 long set", int'(long_len_o), 1);
    expect_pulse(20, 12, "R2 long wrong code");
    fire(12'h200); wait_idle();
    cfg(1'b0);
    chk("R4 long cleared", int'(long_len_o), 0);

    // R5 restart
    restart_i = 1'b1; step(); restart_i = 1'b0; step();
    chk("R5 restart sets long", int'(long_len_o), 1);
    expect_pulse(20, 4, "R5 long after restart");
    fire(12'h002); wait_idle();

    // R9 retrigger during a long pulse
    fire(12'h400);
    k = 0;
    while (k < 5) begin
      if (tick_i) k++;
      step();
    end
    expect_pulse(25, 7, "R9 retrigger");
    evt_i = 12'h010; step(); evt_i = '0;
    wait_idle();

    // R6/R10 outside reset, short pull
    cfg(1'b0);
    expect_pulse(20, 2, "R6 outside reset");
    while (tick_i) step();
    ext_pull = 1'b1; repeat (3) step(); ext_pull = 1'b0;
    repeat (3) step();
    chk("R6 long forced", int'(long_len_o), 1);
    chk("R10 startup set", int'(startup_o), 1);
    wait_idle();
    chk("R10 startup cleared", int'(startup_o), 0);
    chk("R11 no failsafe on release", int'(failsafe_req_o), 0);

    // R11 line held beyond the window
    cfg(1'b0);
    expect_pulse(20, 2, "R11 held outside reset");
    while (tick_i) step();
    ext_pull = 1'b1;
    step();
    while (!rst_drive_o) step();
    while (rst_drive_o) step();
    k = 0;
    while (k < WIN - 3) begin
      if (tick_i) k++;
      step();
    end
    chk("R11 failsafe before window", int'(failsafe_req_o), 0);
    chk("R10 startup while held", int'(startup_o), 1);
    while (k < WIN + 3) begin
      if (tick_i) k++;
      step();
    end
    chk("R11 failsafe after window", int'(failsafe_req_o), 1);
    chk("R11 startup dropped", int'(startup_o), 0);
    ext_pull = 1'b0;
    repeat (10) step();
    chk("R11 failsafe sticky", int'(failsafe_req_o), 1);
    chk("R7 no pulse on release", int'(rst_drive_o), 0);
    chk("R1 code kept", int'(src_code_o), 2);
    chk("R2 all pulses seen", q_tk.size(), 0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule